// File: doc/BRIEF.md
# Bi-Endian Sub-Word Load/Store Lane Unit

This unit sits between a 32-bit load/store pipeline and a word-organized memory whose byte lanes are numbered from the least significant end. It can serve software of either byte order. One mode bit selects the byte order. The mode bit comes from a processor status register and not from the instruction. Byte order is handled only by remapping addresses. The two low address bits of a byte or halfword access are XOR-ed with a constant chosen by the mode before a lane is picked. Data bytes are never reordered, so a full word has the same layout in memory in both modes.

For a request, the unit produces the following outputs combinationally, in the same cycle: the word address, one enable per byte lane, and write data replicated into the proper lanes. Any misalignment is reported in that same cycle. When an aligned load is accepted, the unit records its lane, size and signedness. When the memory returns the word, the unit extracts the addressed byte or halfword, extends it with zeros or with its sign bit, and presents the result one cycle later with a valid strobe. Only one load is outstanding at a time.

Top module: `biendian_lsu`

## Requirements
- R1: Byte access (size code 0): lane = addr[1:0] XOR 3 in big-endian mode (mode bit 1), or addr[1:0] in little-endian mode. Exactly byte enable bit `lane` is set. Write data carries the store byte (bits 7:0) in all four lanes.
- R2: Halfword access (size code 1) with addr[0]=0: lane = addr[1:0] XOR 2 in big-endian mode, or addr[1:0] otherwise. Enables are 4'b0011 for lane 0 and 4'b1100 for lane 2. Write data carries store bits 15:0 in both halves.
- R3: Word access (size code 2 or 3) with addr[1:0]=0: enables are 4'b1111 and write data equals the store data in both modes.
- R4: misaligned_o is set for a valid halfword request with addr[0]=1, and for a valid word request with addr[1:0]≠0. While it is set, all byte enables are 0. A byte request is never misaligned.
- R5: The word address equals addr[31:2] in both modes.
- R6: When rsp_valid_i is high at a clock edge, load_valid_o is high for the following cycle. Otherwise load_valid_o is low.
- R7: A byte or halfword load returns the lane chosen as in R1/R2 at its request. The value is zero-extended when req_unsigned_i was 1 and sign-extended otherwise.
- R8: A word load returns the memory word unchanged, so a word stored in one mode reads back identically after the mode is flipped.
- R9: After reset, load_valid_o and load_data_o are 0.
- R10: With req_valid_i low, all byte enables are 0 and misaligned_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_i | input | 1 | Byte-order mode from status register, 1 = big-endian |
| req_valid_i | input | 1 | Access request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_unsigned_i | input | 1 | Load zero-extension select |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data, right-justified |
| mem_addr_o | output | 30 | Word address to memory |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| misaligned_o | output | 1 | Misaligned access flag |
| rsp_valid_i | input | 1 | Memory read data valid |
| rsp_rdata_i | input | 32 | Memory read word |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The address, enable, write-data and misalignment outputs are due in the same cycle as the request. The bench drives inputs on the falling edge and compares these outputs 1 ns later, before the rising edge that follows. A load result is due in the cycle after the edge that samples rsp_valid_i. The reference model keeps that expectation across the edge and compares it at the next falling edge. A behavioural word memory in the bench holds the values written by stores, so the readback across a flip of the mode bit is checked against real stored data.

// File: rtl/biendian_pkg.sv
package biendian_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } acc_size_e;

    typedef struct packed {
        acc_size_e         size;
        logic [LANE_W-1:0] lane;
        logic              uns;
    } lane_sel_t;

    function automatic logic is_word(acc_size_e s);
        return (s == SZ_WORD) || (s == SZ_WRD2);
    endfunction

    function automatic logic [LANE_W-1:0] order_mask(acc_size_e s, logic big);
        logic [LANE_W-1:0] m;
        m = '0;
        if (big) begin
            case (s)
                SZ_BYTE: m = 2'b11;
                SZ_HALF: m = 2'b10;
                default: m = 2'b00;
            endcase
        end
        return m;
    endfunction

    function automatic logic off_boundary(acc_size_e s, logic [LANE_W-1:0] lo);
        logic r;
        case (s)
            SZ_BYTE: r = 1'b0;
            SZ_HALF: r = lo[0];
            default: r = |lo;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bi_addr_adjust.sv
module bi_addr_adjust
    import biendian_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  acc_size_e                size_i,
    input  logic                     big_i,
    output logic [ADDR_W-LANE_W-1:0] word_addr_o,
    output logic [LANE_W-1:0]        lane_o,
    output logic                     misal_o
);
    logic [LANE_W-1:0] lo;

    always_comb begin
        lo          = addr_i[LANE_W-1:0];
        word_addr_o = addr_i[ADDR_W-1:LANE_W];
        lane_o      = lo ^ order_mask(size_i, big_i);
        misal_o     = off_boundary(size_i, lo);
    end
endmodule

// File: rtl/bi_store_lanes.sv
module bi_store_lanes
    import biendian_pkg::*;
(
    input  logic              active_i,
    input  acc_size_e         size_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [LANE_W-1:0] KIDX = LANE_W'(k);
        always_comb begin
            case (size_i)
                SZ_BYTE: begin
                    be_o[k]            = active_i && (lane_i == KIDX);
                    wdata_o[8*k +: 8]  = wdata_i[7:0];
                end
                SZ_HALF: begin
                    be_o[k]            = active_i && (lane_i[1] == KIDX[1]);
                    wdata_o[8*k +: 8]  = wdata_i[8*(k%2) +: 8];
                end
                default: begin
                    be_o[k]            = active_i;
                    wdata_o[8*k +: 8]  = wdata_i[8*k +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/bi_load_extract.sv
module bi_load_extract
    import biendian_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  lane_sel_t         sel_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output logic              load_valid_o,
    output logic [DATA_W-1:0] load_data_o
);
    lane_sel_t         held;
    logic [DATA_W-1:0] ext;
    logic [7:0]        b;
    logic [15:0]       h;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (capture_i) begin
            held <= sel_i;
        end
    end

    always_comb begin
        b = rsp_rdata_i[8*held.lane +: 8];
        h = rsp_rdata_i[16*held.lane[1] +: 16];
        case (held.size)
            SZ_BYTE: ext = {{(DATA_W-8){~held.uns & b[7]}}, b};
            SZ_HALF: ext = {{(DATA_W-16){~held.uns & h[15]}}, h};
            default: ext = rsp_rdata_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_valid_o <= 1'b0;
            load_data_o  <= '0;
        end else begin
            load_valid_o <= rsp_valid_i;
            if (rsp_valid_i) load_data_o <= ext;
        end
    end

    // R6
    rsp_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_i |=> load_valid_o);
    // R6
    no_rsp_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid_i |=> !load_valid_o);
    // R6
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid_i |=> $stable(load_data_o));
endmodule

// File: rtl/biendian_lsu.sv
module biendian_lsu
    import biendian_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  big_endian_i,
    input  logic                  req_valid_i,
    input  logic                  req_write_i,
    input  logic                  req_unsigned_i,
    input  logic [1:0]            req_size_i,
    input  logic [ADDR_W-1:0]     req_addr_i,
    input  logic [31:0]           req_wdata_i,
    output logic [ADDR_W-3:0]     mem_addr_o,
    output logic [3:0]            mem_be_o,
    output logic [31:0]           mem_wdata_o,
    output logic                  misaligned_o,
    input  logic                  rsp_valid_i,
    input  logic [31:0]           rsp_rdata_i,
    output logic                  load_valid_o,
    output logic [31:0]           load_data_o
);
    acc_size_e         size;
    logic [LANE_W-1:0] lane;
    logic              misal_raw;
    logic              active;
    logic              capture;
    lane_sel_t         sel;

    assign size = acc_size_e'(req_size_i);

    bi_addr_adjust #(.ADDR_W(ADDR_W)) u_adj (
        .addr_i      (req_addr_i),
        .size_i      (size),
        .big_i       (big_endian_i),
        .word_addr_o (mem_addr_o),
        .lane_o      (lane),
        .misal_o     (misal_raw)
    );

    assign misaligned_o = req_valid_i & misal_raw;
    assign active       = req_valid_i & ~misal_raw;
    assign capture      = active & ~req_write_i;

    always_comb begin
        sel.size = size;
        sel.lane = lane;
        sel.uns  = req_unsigned_i;
    end

    bi_store_lanes u_st (
        .active_i (active),
        .size_i   (size),
        .lane_i   (lane),
        .wdata_i  (req_wdata_i),
        .be_o     (mem_be_o),
        .wdata_o  (mem_wdata_o)
    );

    bi_load_extract u_ld (
        .clk          (clk),
        .rst          (rst),
        .capture_i    (capture),
        .sel_i        (sel),
        .rsp_valid_i  (rsp_valid_i),
        .rsp_rdata_i  (rsp_rdata_i),
        .load_valid_o (load_valid_o),
        .load_data_o  (load_data_o)
    );

    // R4
    misal_no_be_chk: assert property (@(posedge clk) disable iff (rst)
        misaligned_o |-> (mem_be_o == 4'b0000));
    // R10
    idle_no_be_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |-> (mem_be_o == 4'b0000 && !misaligned_o));
    // R1
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_size_i == 2'd0) |-> ($countones(mem_be_o) == 1 && !misaligned_o));
    // R2
    half_two_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_size_i == 2'd1 && !req_addr_i[0]) |->
        (mem_be_o == 4'b0011 || mem_be_o == 4'b1100));
    // R3
    word_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_size_i[1] && req_addr_i[1:0] == 2'b00) |->
        (mem_be_o == 4'b1111 && mem_wdata_o == req_wdata_i));
    // R5
    word_addr_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (mem_addr_o == req_addr_i[ADDR_W-1:2]));
endmodule

// File: tb/biendian_lsu_bench.sv
module biendian_lsu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        big;
    logic        rv, rw, ru, rspv;
    logic [1:0]  rs;
    logic [31:0] ra, rwd, rspd;
    logic [29:0] maddr;
    logic [3:0]  mbe;
    logic [31:0] mwd, ldd;
    logic        mis, ldv;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [31:0] mem [16];
    bit          exp_lv;
    logic [31:0] exp_ld;
    int          p_lane, p_size;
    bit          p_uns;

    always #2 clk = ~clk;

    biendian_lsu u_biendian_lsu (
        .clk(clk), .rst(rst), .big_endian_i(big),
        .req_valid_i(rv), .req_write_i(rw), .req_unsigned_i(ru),
        .req_size_i(rs), .req_addr_i(ra), .req_wdata_i(rwd),
        .mem_addr_o(maddr), .mem_be_o(mbe), .mem_wdata_o(mwd),
        .misaligned_o(mis), .rsp_valid_i(rspv), .rsp_rdata_i(rspd),
        .load_valid_o(ldv), .load_data_o(ldd)
    );

    function automatic int m_lane(logic [31:0] a, int sz, bit b);
        int x = 0;
        if (b && sz == 0) x = 3;
        if (b && sz == 1) x = 2;
        return int'(a[1:0]) ^ x;
    endfunction

    function automatic bit m_mis(logic [31:0] a, int sz);
        if (sz == 0) return 0;
        if (sz == 1) return a[0];
        return a[1:0] != 0;
    endfunction

    function automatic logic [3:0] m_be(int sz, int ln);
        if (sz == 0) return 4'(1 << ln);
        if (sz == 1) return 4'(3 << ln);
        return 4'hF;
    endfunction

    function automatic logic [31:0] m_wd(int sz, logic [31:0] d);
        if (sz == 0) return d[7:0] * 32'h0101_0101;
        if (sz == 1) return d[15:0] * 32'h0001_0001;
        return d;
    endfunction

    function automatic logic [31:0] m_ld(logic [31:0] w, int sz, int ln, bit u);
        logic [31:0] v = w >> (8 * ln);
        if (sz == 0) begin
            v = v & 32'hFF;
            if (!u && v[7]) v = v - 32'h100;
        end else if (sz == 1) begin
            v = v & 32'hFFFF;
            if (!u && v[15]) v = v - 32'h1_0000;
        end else v = w;
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: check registered outputs, drive, check combinational, advance model.
    task automatic step(bit v, bit w, bit u, int sz, logic [31:0] a, logic [31:0] d, bit resp);
        string t;
        int    ln;
        bit    ms;
        @(negedge clk);
        chk("R6 load_valid", 32'(ldv), 32'(exp_lv));
        if (exp_lv) chk((p_size >= 2) ? "R8 word load" : "R7 subword load", ldd, exp_ld);
        rv = v; rw = w; ru = u; rs = 2'(sz); ra = a; rwd = d;
        rspv = resp;
        rspd = mem[p_lane >= 0 ? 0 : 0];
        #1;
        ln = m_lane(a, sz, big);
        ms = m_mis(a, sz);
        t  = (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
        chk("R5 word addr", 32'(maddr), a >> 2);
        if (!v) begin
            chk("R10 idle be", 32'(mbe), 0);
            chk("R10 idle misaligned", 32'(mis), 0);
        end else begin
            chk("R4 misaligned", 32'(mis), 32'(ms));
            if (ms) chk("R4 be suppressed", 32'(mbe), 0);
            else begin
                chk({t, " byte enables"}, 32'(mbe), 32'(m_be(sz, ln)));
                if (w) chk({t, " write data"}, mwd, m_wd(sz, d));
            end
        end
        @(posedge clk);
        exp_lv = resp;
        if (resp) exp_ld = m_ld(rspd, p_size, p_lane, p_uns);
        if (v && !ms && w) begin
            for (int k = 0; k < 4; k++)
                if (m_be(sz, ln)[k]) mem[a[5:2]][8*k +: 8] = m_wd(sz, d)[8*k +: 8];
        end
        if (v && !ms && !w) begin
            p_lane = ln; p_size = sz; p_uns = u;
        end
    endtask

    // Load request then response with the bench memory word.
    task automatic do_load(bit u, int sz, logic [31:0] a);
        step(1, 0, u, sz, a, 0, 0);
        @(negedge clk);
        chk("R6 load_valid", 32'(ldv), 32'(exp_lv));
        rv = 0; rspv = 1; rspd = mem[a[5:2]]; ra = a;
        #1;
        @(posedge clk);
        exp_lv = 1;
        exp_ld = m_ld(rspd, p_size, p_lane, p_uns);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        exp_lv = 0; exp_ld = 0; p_lane = 0; p_size = 0; p_uns = 0;
        rst = 1; big = 0; rv = 0; rw = 0; ru = 0; rs = 0; ra = 0; rwd = 0;
        rspv = 0; rspd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset valid", 32'(ldv), 0);
        chk("R9 reset data", ldd, 0);
        rst = 0;

        // R8: store word little-endian, read back big-endian and again little
        step(1, 1, 0, 2, 32'h10, 32'hA1B2_C3D4, 0);
        big = 1;
        do_load(0, 2, 32'h10);
        step(0, 0, 0, 0, 0, 0, 0);
        big = 0;
        do_load(0, 2, 32'h10);
        step(0, 0, 0, 0, 0, 0, 0);
        // R1/R7 byte loads in both modes, signed and unsigned
        for (int m = 0; m < 2; m++) begin
            big = m[0];
            for (int o = 0; o < 4; o++) begin
                do_load(0, 0, 32'h10 + o);
                do_load(1, 0, 32'h10 + o);
            end
            for (int o = 0; o < 4; o += 2) begin
                do_load(0, 1, 32'h10 + o);
                do_load(1, 1, 32'h10 + o);
            end
        end
        // R1/R2 stores at each offset in both modes, then readback
        for (int m = 0; m < 2; m++) begin
            big = m[0];
            for (int o = 0; o < 4; o++) step(1, 1, 0, 0, 32'h20 + o, 32'h80 + o, 0);
            do_load(0, 2, 32'h20);
            step(1, 1, 0, 1, 32'h24, 32'h1234_F00D, 0);
            step(1, 1, 0, 1, 32'h26, 32'h5678_8001, 0);
            do_load(0, 2, 32'h24);
            do_load(0, 1, 32'h26);
        end
        // R4 misaligned cases
        step(1, 1, 0, 1, 32'h31, 32'hFFFF, 0);
        step(1, 1, 0, 2, 32'h32, 32'hFFFF, 0);
        step(1, 0, 0, 3, 32'h33, 0, 0);
        step(1, 0, 0, 1, 32'h33, 0, 0);
        // randomized mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = {$urandom} & 32'hFFFF_FF3F;
            int sz = $urandom_range(0, 3);
            big = $urandom_range(0, 1);
            if ($urandom_range(0, 3) != 0) begin
                if (sz == 1) a[0] = 0;
                if (sz >= 2) a[1:0] = 0;
            end
            if ($urandom_range(0, 1) == 1) step(1, 1, 0, sz, a, $urandom, 0);
            else if (!m_mis(a, sz)) do_load($urandom_range(0, 1), sz, a);
            else step($urandom_range(0, 1), 0, 0, sz, a, 0, 0);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule